// File: doc/BRIEF.md
# Half-Duplex SPI Host Controller

This block is an SPI bus host that software drives through a small word-wide register port. Each transfer moves data in only one direction: it either shifts bytes out on MOSI or collects bytes from MISO. Software picks a clock divider index, the clock polarity and phase, a chip-select number and a direction. It writes the byte count minus one into the length register for that direction, then writes the start bit.

Bytes pass through a 16-byte transmit FIFO and a 16-byte receive FIFO. Software reaches them as 32-bit data words that each hold up to four bytes, with the earliest byte in the low lane. Transfers longer than one FIFO run block by block. Request flags tell software when to refill or drain a FIFO, and software answers each block by writing an acknowledge bit. While the transmit FIFO is empty or the receive FIFO is full, the shift engine parks SCLK at its idle level. No bit is lost or repeated.

Top module: `spi_hd_host`

## Requirements
- R1: After a synchronous active-low reset, the status word reads zero, SCLK and MOSI are low, and every `cs_n` line is high.
- R2: The half-period of SCLK is one `clk` cycle for divider index 0 or 1. For index n ≥ 2 it is n cycles, giving SCLK = clk/(2n). The index sits in bits 3:0 of address 2.
- R3: Address 1 holds the mode. Bit 0 is CPOL and sets the idle level of SCLK. Bit 1 is CPHA: with CPHA=0 data is sampled on the leading edge and changes on the trailing edge, and with CPHA=1 the roles swap. Each byte is sent most significant bit first.
- R4: A write transfer (address 3 bit 0 = 0) sends exactly (address 4 value + 1) bytes. Words written to address 8 are taken low byte first, and only the lanes still owed are used. Lanes or words beyond the count are dropped.
- R5: A read transfer (address 3 bit 0 = 1) clocks in exactly (address 5 value + 1) bytes and holds MOSI low. Each read of address 9 returns up to four bytes, earliest in bits 7:0. A final partial word is zero above the valid bytes.
- R6: Status bit 1 (transmit request) sets while a write transfer runs with the transmit FIFO empty, and also when a write transfer ends. Writing 1 to bit 0 of address 10 clears it.
- R7: Status bit 2 (receive request) sets when the receive FIFO holds 16 bytes during a read, and also when a read transfer ends. Writing 1 to bit 1 of address 10 clears it.
- R8: If the transmit FIFO is empty (write) or the receive FIFO is full (read) at a byte boundary, SCLK holds its idle level and the transfer stays busy until software acts.
- R9: Status bit 0 (busy) is high from an accepted start (bit 0 written to address 6) until the last counted bit has been shifted. A start written while busy is ignored.
- R10: Line `cs_n[k]` is low only when address 7 bit 0 is 1, the enable bit is set, and the select field (address 1, bits 4 upward) equals k. A select value of 1 keeps `cs_n[0]` high.
- R11: While the enable bit (address 0 bit 0) is clear, a start write is ignored and every `cs_n` line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock; SCLK is derived from it |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive FIFO at address 9 |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A register write takes effect at the clock edge that samples the strobe. The status word and receive data appear on `reg_rdata` in the same cycle as the address, so the bench samples them one time step after driving the read. Serial results are captured by a target model that reacts to each SCLK edge of the configured mode. The half-period is measured in `clk` periods between the first two edges of a one-byte transfer. The bench waits for busy or request flags by polling status rather than assuming a cycle count. For the stall checks it first waits until the target model has seen exactly 128 sample edges, then watches SCLK for thirty cycles.

// File: rtl/spi_hd_pkg.sv
// Shared register addresses and shift-engine state encoding for the
// half-duplex SPI host. Assumes a 4-bit word address on the register port.
package spi_hd_pkg;

    typedef enum logic [3:0] {
        RA_ENABLE = 4'd0,
        RA_MODE   = 4'd1,
        RA_CLKSEL = 4'd2,
        RA_DIR    = 4'd3,
        RA_WLEN   = 4'd4,
        RA_RLEN   = 4'd5,
        RA_START  = 4'd6,
        RA_CSCTL  = 4'd7,
        RA_TXDATA = 4'd8,
        RA_RXDATA = 4'd9,
        RA_ACK    = 4'd10,
        RA_STATUS = 4'd11
    } reg_addr_e;

    typedef enum logic [1:0] {
        EG_IDLE = 2'd0,
        EG_WAIT = 2'd1,
        EG_LEAD = 2'd2,
        EG_TRAIL = 2'd3
    } eng_state_e;

endpackage

// File: rtl/spi_hd_fifo.sv
// Byte FIFO with multi-byte push and pop per cycle.
// Pushes and pops up to IN_LANES / OUT_LANES bytes; lane 0 is the earliest.
// Assumes DEPTH is a power of two and that the caller never asks for more
// bytes than are free (push) or stored (pop). Pop lanes beyond the stored
// count read as zero.
module spi_hd_fifo #(
    parameter int DEPTH     = 16,
    parameter int IN_LANES  = 1,
    parameter int OUT_LANES = 1,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(IN_LANES + 1),
    localparam int OW = $clog2(OUT_LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [IW-1:0]          push_n,
    input  logic [8*IN_LANES-1:0]  push_data,
    input  logic [OW-1:0]          pop_n,
    output logic [8*OUT_LANES-1:0] pop_data,
    output logic [CW-1:0]          count
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;

    // Store each pushed lane at consecutive slots.
    always_ff @(posedge clk) begin
        for (int i = 0; i < IN_LANES; i++) begin
            if (i < int'(push_n)) begin
                mem[wptr + PW'(i)] <= push_data[8*i +: 8];
            end
        end
    end

    // Advance pointers and occupancy; flush empties the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + PW'(push_n);
            rptr  <= rptr + PW'(pop_n);
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // Present the oldest bytes, zero beyond the stored count.
    always_comb begin
        for (int i = 0; i < OUT_LANES; i++) begin
            pop_data[8*i +: 8] = (i < int'(count)) ? mem[rptr + PW'(i)] : 8'h00;
        end
    end

endmodule

// File: rtl/spi_hd_engine.sv
// Serial shift engine: runs one counted transfer in one direction.
// Each bit spans a leading and a trailing half-period; data is launched at
// the start of the leading half and sampled on entry to the trailing half.
// Between bytes it waits at idle SCLK level until a byte (write) or room
// (read) is available. Assumes start is only pulsed while idle.
module spi_hd_engine
    import spi_hd_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             start,
    input  logic             dir_rd,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [IDX_W-1:0] clk_idx,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [7:0]       tx_byte,
    input  logic             tx_avail,
    input  logic             rx_room,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    output logic             busy,
    output logic             xfer_end,
    output logic             sclk,
    output logic             mosi
);

    eng_state_e       state;
    logic [IDX_W-1:0] timer;
    logic [IDX_W-1:0] half_m1;
    logic [IDX_W-1:0] hm1_q;
    logic [2:0]       bit_idx;
    logic [LEN_W-1:0] left;
    logic             rd_q;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx;
    logic             tick;
    logic             byte_go;

    // Half-period minus one from the divider index (index 0 and 1 share 1).
    assign half_m1 = (clk_idx < IDX_W'(2)) ? '0 : clk_idx - IDX_W'(1);

    assign tick     = run_en && (timer == '0);
    assign byte_go  = (state == EG_WAIT) && run_en && (rd_q ? rx_room : tx_avail);
    assign tx_pop   = byte_go && !rd_q;
    assign rx_push  = (state == EG_LEAD) && tick && (bit_idx == 3'd0) && rd_q;
    assign rx_byte  = {sh_rx[6:0], miso};
    assign xfer_end = (state == EG_TRAIL) && tick && (bit_idx == 3'd0) && (left == '0);
    assign busy     = (state != EG_IDLE);
    assign sclk     = cpol ^ (cpha ? (state == EG_LEAD) : (state == EG_TRAIL));
    assign mosi     = !rd_q && ((state == EG_LEAD) || (state == EG_TRAIL)) && sh_tx[7];

    // Sequence bytes and bits through the lead/trail halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= EG_IDLE;
            timer   <= '0;
            hm1_q   <= '0;
            bit_idx <= '0;
            left    <= '0;
            rd_q    <= 1'b0;
            sh_tx   <= '0;
            sh_rx   <= '0;
        end else begin
            unique case (state)
                EG_IDLE: begin
                    if (start) begin
                        state <= EG_WAIT;
                        left  <= len_m1;
                        rd_q  <= dir_rd;
                        hm1_q <= half_m1;
                        sh_tx <= '0;
                    end
                end
                EG_WAIT: begin
                    if (byte_go) begin
                        sh_tx   <= rd_q ? 8'h00 : tx_byte;
                        bit_idx <= 3'd7;
                        timer   <= hm1_q;
                        state   <= EG_LEAD;
                    end
                end
                EG_LEAD: begin
                    if (run_en) begin
                        if (timer == '0) begin
                            timer <= hm1_q;
                            sh_rx <= {sh_rx[6:0], miso};
                            state <= EG_TRAIL;
                        end else begin
                            timer <= timer - IDX_W'(1);
                        end
                    end
                end
                EG_TRAIL: begin
                    if (run_en) begin
                        if (timer == '0) begin
                            timer <= hm1_q;
                            if (bit_idx == 3'd0) begin
                                sh_tx <= '0;
                                if (left == '0) begin
                                    state <= EG_IDLE;
                                end else begin
                                    left  <= left - LEN_W'(1);
                                    state <= EG_WAIT;
                                end
                            end else begin
                                bit_idx <= bit_idx - 3'd1;
                                sh_tx   <= {sh_tx[6:0], 1'b0};
                                state   <= EG_LEAD;
                            end
                        end else begin
                            timer <= timer - IDX_W'(1);
                        end
                    end
                end
                default: state <= EG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_hd_host.sv
// Register-programmed half-duplex SPI host.
// Decodes the register port, holds configuration, packs and unpacks 32-bit
// data words to the byte FIFOs, keeps the block request flags and drives
// the chip selects. Assumes FIFO_DEPTH is a power of two and at least 4.
module spi_hd_host
    import spi_hd_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_CS     = 2,
    parameter int LEN_W      = 16,
    parameter int IDX_W      = 4,
    localparam int LANES = 4,
    localparam int CW    = $clog2(FIFO_DEPTH + 1),
    localparam int LW    = $clog2(LANES + 1),
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    logic             en_q, cpol_q, cpha_q, dir_q, cs_on_q, xfer_rd_q;
    logic [SEL_W-1:0] sel_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] wlen_q, rlen_q;
    logic [LEN_W:0]   tx_left;
    logic             tx_req_q, rx_req_q;
    logic             busy, xfer_end, start_ok, tx_ack, rx_ack;
    logic             tx_pop, rx_push;
    logic [7:0]       tx_byte, rx_byte;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic [LW-1:0]    tx_push_n, rx_pop_n;
    logic [8*LANES-1:0] rx_word;
    int               tx_n, rx_n;

    function automatic logic hit(input logic [3:0] a, input reg_addr_e r);
        return a == r;
    endfunction

    assign start_ok = reg_wr && hit(reg_addr, RA_START) && reg_wdata[0] && en_q && !busy;
    assign tx_ack   = reg_wr && hit(reg_addr, RA_ACK) && reg_wdata[0];
    assign rx_ack   = reg_wr && hit(reg_addr, RA_ACK) && reg_wdata[1];

    // Bytes to take from a data word: owed, free and lane limits.
    always_comb begin
        tx_n = LANES;
        if (int'(tx_left) < tx_n) tx_n = int'(tx_left);
        if (FIFO_DEPTH - int'(tx_cnt) < tx_n) tx_n = FIFO_DEPTH - int'(tx_cnt);
        tx_push_n = (reg_wr && hit(reg_addr, RA_TXDATA)) ? LW'(tx_n) : '0;
        rx_n = (int'(rx_cnt) < LANES) ? int'(rx_cnt) : LANES;
        rx_pop_n = (reg_rd && hit(reg_addr, RA_RXDATA)) ? LW'(rx_n) : '0;
    end

    // Configuration registers and transfer bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; sel_q <= '0;
            idx_q <= '0; dir_q <= 1'b0; wlen_q <= '0; rlen_q <= '0;
            cs_on_q <= 1'b0; xfer_rd_q <= 1'b0; tx_left <= '0;
        end else begin
            if (reg_wr && hit(reg_addr, RA_ENABLE)) en_q <= reg_wdata[0];
            if (reg_wr && hit(reg_addr, RA_MODE)) begin
                cpol_q <= reg_wdata[0];
                cpha_q <= reg_wdata[1];
                sel_q  <= reg_wdata[4 +: SEL_W];
            end
            if (reg_wr && hit(reg_addr, RA_CLKSEL)) idx_q <= reg_wdata[IDX_W-1:0];
            if (reg_wr && hit(reg_addr, RA_DIR))    dir_q <= reg_wdata[0];
            if (reg_wr && hit(reg_addr, RA_WLEN))   wlen_q <= reg_wdata[LEN_W-1:0];
            if (reg_wr && hit(reg_addr, RA_RLEN))   rlen_q <= reg_wdata[LEN_W-1:0];
            if (reg_wr && hit(reg_addr, RA_CSCTL))  cs_on_q <= reg_wdata[0];
            if (start_ok) begin
                xfer_rd_q <= dir_q;
                tx_left   <= dir_q ? '0 : {1'b0, wlen_q} + (LEN_W+1)'(1);
            end else begin
                tx_left <= tx_left - (LEN_W+1)'(tx_push_n);
            end
        end
    end

    // Block request flags: acknowledge clears, empty/full or end sets.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            tx_req_q <= 1'b0;
            rx_req_q <= 1'b0;
        end else begin
            if (tx_ack) tx_req_q <= 1'b0;
            else if (!xfer_rd_q && ((busy && tx_cnt == '0) || xfer_end)) tx_req_q <= 1'b1;
            if (rx_ack) rx_req_q <= 1'b0;
            else if (xfer_rd_q && ((busy && rx_cnt == CW'(FIFO_DEPTH)) || xfer_end)) rx_req_q <= 1'b1;
        end
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, RA_STATUS)) reg_rdata = {29'd0, rx_req_q, tx_req_q, busy};
        else if (hit(reg_addr, RA_RXDATA)) reg_rdata = rx_word;
    end

    // One active-low select per target.
    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        assign cs_n[k] = !(en_q && cs_on_q && (sel_q == SEL_W'(k)));
    end

    spi_hd_fifo #(.DEPTH(FIFO_DEPTH), .IN_LANES(LANES), .OUT_LANES(1)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(start_ok),
        .push_n(tx_push_n), .push_data(reg_wdata),
        .pop_n(tx_pop), .pop_data(tx_byte), .count(tx_cnt)
    );

    spi_hd_fifo #(.DEPTH(FIFO_DEPTH), .IN_LANES(1), .OUT_LANES(LANES)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(start_ok),
        .push_n(rx_push), .push_data(rx_byte),
        .pop_n(rx_pop_n), .pop_data(rx_word), .count(rx_cnt)
    );

    spi_hd_engine #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run_en(en_q), .start(start_ok),
        .dir_rd(dir_q), .len_m1(dir_q ? rlen_q : wlen_q), .clk_idx(idx_q),
        .cpol(cpol_q), .cpha(cpha_q), .tx_byte(tx_byte),
        .tx_avail(tx_cnt != '0), .rx_room(rx_cnt != CW'(FIFO_DEPTH)),
        .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .busy(busy), .xfer_end(xfer_end), .sclk(sclk), .mosi(mosi)
    );

endmodule

// File: rtl/spi_hd_host_chk.sv
// Property checker for spi_hd_host, attached by bind. Observes the top's
// pins and the internal state that separate logic drives.
module spi_hd_host_chk #(
    parameter int NUM_CS = 2,
    parameter int SEL_W  = 1,
    parameter int CW     = 5,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              cpol,
    input logic              busy,
    input logic              en,
    input logic [NUM_CS-1:0] cs_n,
    input logic [SEL_W-1:0]  sel,
    input logic [CW-1:0]     tx_cnt,
    input logic              rx_req,
    input logic              rx_ack,
    input logic              start_ok
);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R10
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R10
    sel_hides_cs0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_W'(1)) |-> cs_n[0]);

    // R7
    rx_req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_req) |-> $past(rx_ack || start_ok));

    // R4
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_cnt) <= DEPTH);

    // R11
    no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy);

endmodule

bind spi_hd_host spi_hd_host_chk #(
    .NUM_CS(NUM_CS), .SEL_W(SEL_W), .CW(CW), .DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cpol(cpol_q), .busy(busy),
    .en(en_q), .cs_n(cs_n), .sel(sel_q), .tx_cnt(tx_cnt),
    .rx_req(rx_req_q), .rx_ack(rx_ack), .start_ok(start_ok)
);

// File: tb/tb_spi_hd_host.sv
// Directed bench for spi_hd_host with a mode-aware target model.
module tb_spi_hd_host;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic sclk, mosi, miso = 1'b0;
    logic [NCS-1:0] cs_n;

    int n_checks = 0, n_fail = 0;

    spi_hd_host #(.NUM_CS(NCS)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Target model state
    logic tb_cpol = 1'b0, tb_cpha = 1'b0, slv_on = 1'b0;
    int samp_cnt = 0, shift_idx = 0, edge_n = 0;
    longint t_e1 = 0, t_e2 = 0;
    logic [7:0] cap_sh = '0;
    logic [7:0] cap [32];
    logic [7:0] src [32];

    // Sample MOSI on the sampling edge, launch MISO on the other edge.
    always @(sclk) begin
        if (slv_on) begin
            edge_n++;
            if (edge_n == 1) t_e1 = $time;
            if (edge_n == 2) t_e2 = $time;
            if ((sclk != tb_cpol) ^ tb_cpha) begin
                cap_sh = {cap_sh[6:0], mosi};
                samp_cnt++;
                if (samp_cnt % 8 == 0 && samp_cnt <= 256) cap[samp_cnt/8 - 1] = cap_sh;
            end else begin
                if (shift_idx < 256) miso = src[shift_idx/8][7 - (shift_idx % 8)];
                shift_idx++;
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_status(input int b, input logic v, output logic ok);
        logic [31:0] s;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            reg_read(4'd11, s);
            if (s[b] == v) begin ok = 1'b1; break; end
        end
    endtask

    task automatic arm(input logic pol, input logic pha);
        slv_on = 1'b0;
        tb_cpol = pol; tb_cpha = pha;
        reg_write(4'd1, {30'd0, pha, pol});
        samp_cnt = 0; edge_n = 0; cap_sh = '0;
        for (int i = 0; i < 32; i++) cap[i] = 8'h00;
        if (pha) begin shift_idx = 0; miso = 1'b0; end
        else begin miso = src[0][7]; shift_idx = 1; end
        slv_on = 1'b1;
    endtask

    task automatic sclk_stable(output logic ok);
        logic s;
        s = sclk; ok = 1'b1;
        repeat (30) begin @(negedge clk); if (sclk !== s) ok = 1'b0; end
    endtask

    task automatic t_reset;
        logic [31:0] s;
        reg_read(4'd11, s);
        check("R1 status", s, 0);
        check("R1 sclk", sclk, 0);
        check("R1 mosi", mosi, 0);
        check("R1 cs_n", cs_n, 2'b11);
    endtask

    task automatic t_divider(input int idx, input int half);
        logic ok;
        reg_write(4'd2, idx);
        reg_write(4'd3, 0);
        reg_write(4'd4, 0);
        arm(1'b0, 1'b0);
        reg_write(4'd6, 1);
        reg_write(4'd8, 32'h0000_005A);
        wait_status(0, 1'b0, ok);
        check("R2 half period", (t_e2 - t_e1) / CLK_PERIOD, half);
    endtask

    task automatic t_write_basic;
        logic ok;
        logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        reg_write(4'd2, 0);
        reg_write(4'd3, 0);
        reg_write(4'd4, 5);
        arm(1'b0, 1'b0);
        reg_write(4'd6, 1);
        reg_write(4'd8, 32'h4433_2211);
        reg_write(4'd8, 32'hDEAD_6655);
        reg_write(4'd8, 32'h9988_7766);
        wait_status(0, 1'b0, ok);
        check("R9 busy falls", ok, 1);
        check("R4 bit count", samp_cnt, 48);
        for (int i = 0; i < 6; i++) check("R4 byte order", cap[i], exp[i]);
    endtask

    task automatic t_read_basic;
        logic ok;
        logic [31:0] w, s;
        src[0] = 8'hA1; src[1] = 8'hB2; src[2] = 8'hC3;
        src[3] = 8'hD4; src[4] = 8'hE5; src[5] = 8'hF6;
        reg_write(4'd2, 2);
        reg_write(4'd3, 1);
        reg_write(4'd5, 5);
        arm(1'b1, 1'b1);
        reg_write(4'd6, 1);
        wait_status(0, 1'b0, ok);
        check("R3 mode3 sample count", samp_cnt, 48);
        check("R5 mosi low", {cap[0], cap[1], cap[2], cap[3], cap[4], cap[5]}, 0);
        reg_read(4'd11, s);
        check("R7 set at read end", s[2], 1);
        reg_read(4'd9, w);
        check("R5 first word", w, 32'hD4C3_B2A1);
        reg_read(4'd9, w);
        check("R5 partial word", w, 32'h0000_F6E5);
        reg_write(4'd10, 2);
        reg_read(4'd11, s);
        check("R7 ack clears", s[2], 0);
    endtask

    task automatic t_write_blocks;
        logic ok, st;
        logic [31:0] s;
        reg_write(4'd2, 2);
        reg_write(4'd3, 0);
        reg_write(4'd4, 19);
        arm(1'b0, 1'b1);
        reg_write(4'd6, 1);
        wait_status(1, 1'b1, ok);
        check("R6 set on empty FIFO", ok, 1);
        for (int w = 0; w < 4; w++)
            reg_write(4'd8, {8'h13 + 8'(4*w), 8'h12 + 8'(4*w), 8'h11 + 8'(4*w), 8'h10 + 8'(4*w)});
        reg_write(4'd10, 1);
        reg_read(4'd11, s);
        check("R6 ack clears", s[1], 0);
        for (int i = 0; i < 20000 && samp_cnt < 128; i++) @(negedge clk);
        sclk_stable(st);
        check("R8 write stall holds sclk", st, 1);
        check("R8 write stall bit count", samp_cnt, 128);
        reg_read(4'd11, s);
        check("R8 still busy", s[0], 1);
        check("R6 request after block", s[1], 1);
        reg_write(4'd8, 32'h2322_2120);
        reg_write(4'd10, 1);
        wait_status(0, 1'b0, ok);
        check("R4 long bit count", samp_cnt, 160);
        for (int i = 0; i < 16; i++) check("R3 mode1 bytes", cap[i], 8'h10 + 8'(i));
        for (int i = 16; i < 20; i++) check("R4 second block", cap[i], 8'h20 + 8'(i - 16));
    endtask

    task automatic t_read_blocks;
        logic ok, st;
        logic [31:0] w, s;
        for (int i = 0; i < 20; i++) src[i] = 8'h30 + 8'(i);
        reg_write(4'd2, 1);
        reg_write(4'd3, 1);
        reg_write(4'd5, 19);
        arm(1'b1, 1'b0);
        reg_write(4'd6, 1);
        wait_status(2, 1'b1, ok);
        check("R7 set on full FIFO", ok, 1);
        repeat (6) @(negedge clk);
        sclk_stable(st);
        check("R8 read stall holds sclk", st, 1);
        check("R8 read stall bit count", samp_cnt, 128);
        for (int i = 0; i < 4; i++) begin
            reg_read(4'd9, w);
            check("R5 block word", w, {8'h33 + 8'(4*i), 8'h32 + 8'(4*i), 8'h31 + 8'(4*i), 8'h30 + 8'(4*i)});
        end
        reg_write(4'd10, 2);
        wait_status(0, 1'b0, ok);
        reg_read(4'd11, s);
        check("R7 set at end", s[2], 1);
        reg_read(4'd9, w);
        check("R3 mode2 tail word", w, 32'h4342_4140);
    endtask

    task automatic t_busy_ignore;
        logic ok;
        logic [31:0] s;
        reg_write(4'd2, 2);
        reg_write(4'd3, 0);
        reg_write(4'd4, 1);
        arm(1'b0, 1'b0);
        reg_write(4'd6, 1);
        reg_write(4'd8, 32'h0000_BBAA);
        reg_write(4'd6, 1);
        wait_status(0, 1'b0, ok);
        repeat (10) @(negedge clk);
        reg_read(4'd11, s);
        check("R9 restart ignored", s[0], 0);
        check("R9 bit count", samp_cnt, 16);
        check("R9 data", {cap[0], cap[1]}, 16'hAABB);
    endtask

    task automatic t_chip_select;
        reg_write(4'd1, 32'h0000_0000);
        reg_write(4'd7, 1);
        @(negedge clk);
        check("R10 select 0", cs_n, 2'b10);
        reg_write(4'd1, 32'h0000_0010);
        @(negedge clk);
        check("R10 select 1 hides cs0", cs_n, 2'b01);
        reg_write(4'd7, 0);
        @(negedge clk);
        check("R10 control off", cs_n, 2'b11);
    endtask

    task automatic t_disabled;
        logic [31:0] s;
        reg_write(4'd7, 1);
        reg_write(4'd0, 0);
        @(negedge clk);
        check("R11 cs inactive", cs_n, 2'b11);
        reg_write(4'd4, 0);
        reg_write(4'd6, 1);
        repeat (3) @(negedge clk);
        reg_read(4'd11, s);
        check("R11 start ignored", s[0], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        reg_write(4'd0, 1);
        t_divider(0, 1);
        t_divider(1, 1);
        t_divider(3, 3);
        t_divider(15, 15);
        t_write_basic();
        t_read_basic();
        t_write_blocks();
        t_read_blocks();
        t_busy_ignore();
        t_chip_select();
        t_disabled();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule